// File: doc/BRIEF.md
# Scaler Coefficient Control Register Interface

This block is the software-facing control plane of a video scaler. A 32-bit word-addressed slave bus with four byte enables sets a run flag, an edge-adaptive selection flag, the output frame width and height, and an edge threshold. It also loads polyphase filter coefficients. Software first writes every tap value of one phase into a set of staging registers. It then writes the phase number to the horizontal or vertical phase register. That write copies all staged taps into the coefficient store, into the bank chosen by the matching write-bank register. Bit 15 of the phase value sends the copy to the edge coefficient set of that phase rather than the normal set.

Run settings are copied into shadow registers on every frame-start pulse, so software may rewrite them at any time without disturbing the frame in progress. The shadowed values drive the scaler datapath: the run flag (also the status bit), the edge-enable flag, the frame size, the threshold already multiplied by the number of colour planes, and the horizontal and vertical read banks. The datapath fetches one coefficient per request through a registered read port, which always uses the shadowed read bank of the chosen direction. While the scaler runs, a commit aimed at the bank that direction is reading is discarded, so the coefficients in use cannot be torn.

Top module: `scl_coef_regs`

## Requirements
- R1: After reset every register reads zero. This includes control bit 0 (run request) when RUN_CTRL=1. The status bit, the shadow outputs and bus_rdata are zero. When RUN_CTRL=0, control bit 0 is held at 1 and ignores writes.
- R2: A bus write updates only the byte lanes whose enable bit is set. Lane k covers wdata[8k+7:8k]. Bits above a register's width are dropped.
- R3: Control word address 0: bit 0 is the run request and bit 1 is the edge-adaptive enable. Every other bit reads 0. Address 2 (interrupt) and addresses 6 and 7 read 0 and ignore writes.
- R4: The status bit (address 1 bit 0, and run_active) is loaded from the run request only on a frame_start cycle. It reads 0 until the first frame start after the request is set. Clearing the request takes effect at the next frame start, not before.
- R5: out_width (address 3), out_height (address 4), edge_adapt, h_rd_bank (address 9) and v_rd_bank (address 11) take the register values present on a frame_start cycle. Register writes between frame starts leave these outputs unchanged.
- R6: edge_thresh equals the address 5 value times PLANES, latched on frame_start.
- R7: Addresses 14 to 14+NTAPS-1 hold staged tap values that read back as written. NTAPS is the larger of the two tap counts. Writing them changes no stored coefficient.
- R8: A write to address 12 (horizontal) or 13 (vertical) stores all staged taps at the phase in bits [PH_W-1:0]. It uses the bank in address 8 (horizontal) or 10 (vertical). Every such write commits, even when the phase number repeats.
- R9: When bit 15 of the written phase value is 1, the commit targets the edge set of that phase. When it is 0, the commit targets the normal set. The phase register reads back bit 15 and the phase bits.
- R10: A cr_en pulse with cr_dir (0 horizontal, 1 vertical), cr_edge, cr_phase and cr_tap presents the stored coefficient on cr_data one cycle later. The coefficient is taken from the shadowed read bank of that direction.
- R11: While run_active is 1, a commit whose bank equals the shadowed read bank of its direction is dropped. Commits to other banks, and all commits while run_active is 0, are stored.
- R12: bus_rdata presents the value of the register addressed in a bus_rd cycle on the following cycle, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| frame_start | input | 1 | Frame boundary pulse that loads the shadows |
| run_active | output | 1 | Shadowed run flag (status) |
| edge_adapt | output | 1 | Shadowed edge-adaptive enable |
| out_width | output | DIM_W | Shadowed output width |
| out_height | output | DIM_W | Shadowed output height |
| edge_thresh | output | TH_W+clog2(PLANES+1) | Shadowed threshold times PLANES |
| h_rd_bank | output | clog2(BANKS) | Shadowed horizontal read bank |
| v_rd_bank | output | clog2(BANKS) | Shadowed vertical read bank |
| cr_en | input | 1 | Coefficient read request |
| cr_dir | input | 1 | Read direction, 0 horizontal, 1 vertical |
| cr_edge | input | 1 | Read from the edge set |
| cr_phase | input | clog2(PHASES) | Phase to read |
| cr_tap | input | clog2(NTAPS) | Tap to read |
| cr_data | output | COEF_W | Coefficient, one cycle after cr_en |

## Verification
The bench builds the block with four banks, four phases, four horizontal and three vertical taps, 12-bit coefficients, 12-bit dimensions, a 10-bit threshold, three planes and run control enabled. Four banks let one scenario keep a running read bank in use while commits land in other banks. The bank register is then switched and the new contents appear at the next frame start. The unequal tap counts exercise NTAPS as the maximum. The 12-bit dimensions show byte lanes that partly fall outside a register. Three planes give a threshold product whose width exceeds the register width.

// File: rtl/scl_coef_pkg.sv
package scl_coef_pkg;

  // word addresses decoded by the register file
  localparam int unsigned RA_CTRL = 0;
  localparam int unsigned RA_STAT = 1;
  localparam int unsigned RA_OWID = 3;
  localparam int unsigned RA_OHGT = 4;
  localparam int unsigned RA_ETHR = 5;
  localparam int unsigned RA_HWB  = 8;
  localparam int unsigned RA_HRB  = 9;
  localparam int unsigned RA_VWB  = 10;
  localparam int unsigned RA_VRB  = 11;
  localparam int unsigned RA_HPH  = 12;
  localparam int unsigned RA_VPH  = 13;
  localparam int unsigned RA_TAP0 = 14;

  typedef enum logic {DIR_H = 1'b0, DIR_V = 1'b1} dir_e;

  // byte-lane merge of a write into the current register value
  function automatic logic [31:0] be_merge(input logic [31:0] cur,
                                           input logic [31:0] wd,
                                           input logic [3:0]  be);
    logic [31:0] res;
    for (int b = 0; b < 4; b++) begin
      res[b*8 +: 8] = be[b] ? wd[b*8 +: 8] : cur[b*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/scl_coef_csr.sv
module scl_coef_csr
  import scl_coef_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DIM_W   = 16,
  parameter int TH_W    = 16,
  parameter int BK_W    = 1,
  parameter int PH_W    = 3,
  parameter int NTAPS   = 4,
  parameter int COEF_W  = 16,
  parameter int RUN_CTRL = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  input  logic [3:0]              be,
  input  logic                    status_i,
  output logic [31:0]             rdata,
  output logic                    go_o,
  output logic                    edge_en_o,
  output logic [DIM_W-1:0]        width_o,
  output logic [DIM_W-1:0]        height_o,
  output logic [TH_W-1:0]         thresh_o,
  output logic [BK_W-1:0]         h_rd_bank_o,
  output logic [BK_W-1:0]         v_rd_bank_o,
  output logic [NTAPS*COEF_W-1:0] taps_o,
  output logic                    cm_vld_o,
  output logic                    cm_dir_o,
  output logic                    cm_edge_o,
  output logic [PH_W-1:0]         cm_phase_o,
  output logic [BK_W-1:0]         cm_bank_o
);

  localparam logic [15:0] PH_MASK = 16'h8000 | 16'((1 << PH_W) - 1);
  localparam logic [1:0]  CTRL_RST = (RUN_CTRL != 0) ? 2'b00 : 2'b01;

  logic [1:0]        ctrl_q, ctrl_d;
  logic [DIM_W-1:0]  wid_q, wid_d, hgt_q, hgt_d;
  logic [TH_W-1:0]   thr_q, thr_d;
  logic [BK_W-1:0]   hwb_q, hwb_d, hrb_q, hrb_d, vwb_q, vwb_d, vrb_q, vrb_d;
  logic [15:0]       hph_q, hph_d, vph_q, vph_d;
  logic [COEF_W-1:0] tap_q [NTAPS];
  logic [COEF_W-1:0] tap_d [NTAPS];
  logic [31:0]       rd_val, merged, rdata_q, rdata_d;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ra);
    return a == ADDR_W'(ra);
  endfunction

  // current value of the addressed register
  always_comb begin
    rd_val = '0;
    if (hit(addr, RA_CTRL)) rd_val = 32'(ctrl_q);
    if (hit(addr, RA_STAT)) rd_val = 32'(status_i);
    if (hit(addr, RA_OWID)) rd_val = 32'(wid_q);
    if (hit(addr, RA_OHGT)) rd_val = 32'(hgt_q);
    if (hit(addr, RA_ETHR)) rd_val = 32'(thr_q);
    if (hit(addr, RA_HWB))  rd_val = 32'(hwb_q);
    if (hit(addr, RA_HRB))  rd_val = 32'(hrb_q);
    if (hit(addr, RA_VWB))  rd_val = 32'(vwb_q);
    if (hit(addr, RA_VRB))  rd_val = 32'(vrb_q);
    if (hit(addr, RA_HPH))  rd_val = 32'(hph_q);
    if (hit(addr, RA_VPH))  rd_val = 32'(vph_q);
    for (int i = 0; i < NTAPS; i++) begin
      if (hit(addr, RA_TAP0 + i)) rd_val = 32'(tap_q[i]);
    end
  end

  assign merged = be_merge(rd_val, wdata, be);

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    wid_d  = wid_q;
    hgt_d  = hgt_q;
    thr_d  = thr_q;
    hwb_d  = hwb_q;
    hrb_d  = hrb_q;
    vwb_d  = vwb_q;
    vrb_d  = vrb_q;
    hph_d  = hph_q;
    vph_d  = vph_q;
    for (int i = 0; i < NTAPS; i++) tap_d[i] = tap_q[i];
    if (wr_en) begin
      if (hit(addr, RA_CTRL)) ctrl_d = {merged[1], (RUN_CTRL != 0) ? merged[0] : 1'b1};
      if (hit(addr, RA_OWID)) wid_d = merged[DIM_W-1:0];
      if (hit(addr, RA_OHGT)) hgt_d = merged[DIM_W-1:0];
      if (hit(addr, RA_ETHR)) thr_d = merged[TH_W-1:0];
      if (hit(addr, RA_HWB))  hwb_d = merged[BK_W-1:0];
      if (hit(addr, RA_HRB))  hrb_d = merged[BK_W-1:0];
      if (hit(addr, RA_VWB))  vwb_d = merged[BK_W-1:0];
      if (hit(addr, RA_VRB))  vrb_d = merged[BK_W-1:0];
      if (hit(addr, RA_HPH))  hph_d = merged[15:0] & PH_MASK;
      if (hit(addr, RA_VPH))  vph_d = merged[15:0] & PH_MASK;
      for (int i = 0; i < NTAPS; i++) begin
        if (hit(addr, RA_TAP0 + i)) tap_d[i] = merged[COEF_W-1:0];
      end
    end
    rdata_d = rd_en ? rd_val : rdata_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      wid_q   <= '0;
      hgt_q   <= '0;
      thr_q   <= '0;
      hwb_q   <= '0;
      hrb_q   <= '0;
      vwb_q   <= '0;
      vrb_q   <= '0;
      hph_q   <= '0;
      vph_q   <= '0;
      rdata_q <= '0;
      for (int i = 0; i < NTAPS; i++) tap_q[i] <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      wid_q   <= wid_d;
      hgt_q   <= hgt_d;
      thr_q   <= thr_d;
      hwb_q   <= hwb_d;
      hrb_q   <= hrb_d;
      vwb_q   <= vwb_d;
      vrb_q   <= vrb_d;
      hph_q   <= hph_d;
      vph_q   <= vph_d;
      rdata_q <= rdata_d;
      for (int i = 0; i < NTAPS; i++) tap_q[i] <= tap_d[i];
    end
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap_out
    assign taps_o[g*COEF_W +: COEF_W] = tap_q[g];
  end

  // commit request: phase register write carries phase and edge flag
  assign cm_vld_o   = wr_en && (hit(addr, RA_HPH) || hit(addr, RA_VPH));
  assign cm_dir_o   = hit(addr, RA_VPH) ? DIR_V : DIR_H;
  assign cm_edge_o  = merged[15];
  assign cm_phase_o = merged[PH_W-1:0];
  assign cm_bank_o  = cm_dir_o ? vwb_q : hwb_q;

  assign rdata       = rdata_q;
  assign go_o        = ctrl_q[0];
  assign edge_en_o   = ctrl_q[1];
  assign width_o     = wid_q;
  assign height_o    = hgt_q;
  assign thresh_o    = thr_q;
  assign h_rd_bank_o = hrb_q;
  assign v_rd_bank_o = vrb_q;

endmodule

// File: rtl/scl_coef_shadow.sv
module scl_coef_shadow #(
  parameter int DIM_W  = 16,
  parameter int TH_W   = 16,
  parameter int THO_W  = 18,
  parameter int BK_W   = 1,
  parameter int PLANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             go_i,
  input  logic             edge_en_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  input  logic [TH_W-1:0]  thresh_i,
  input  logic [BK_W-1:0]  h_rd_bank_i,
  input  logic [BK_W-1:0]  v_rd_bank_i,
  output logic             run_o,
  output logic             edge_en_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o,
  output logic [THO_W-1:0] thresh_o,
  output logic [BK_W-1:0]  h_rd_bank_o,
  output logic [BK_W-1:0]  v_rd_bank_o
);

  logic             run_q, run_d, een_q, een_d;
  logic [DIM_W-1:0] wid_q, wid_d, hgt_q, hgt_d;
  logic [THO_W-1:0] thr_q, thr_d;
  logic [BK_W-1:0]  hrb_q, hrb_d, vrb_q, vrb_d;

  always_comb begin
    run_d = run_q;
    een_d = een_q;
    wid_d = wid_q;
    hgt_d = hgt_q;
    thr_d = thr_q;
    hrb_d = hrb_q;
    vrb_d = vrb_q;
    if (frame_start) begin
      run_d = go_i;
      een_d = edge_en_i;
      wid_d = width_i;
      hgt_d = height_i;
      thr_d = THO_W'(thresh_i) * THO_W'(PLANES);
      hrb_d = h_rd_bank_i;
      vrb_d = v_rd_bank_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      een_q <= 1'b0;
      wid_q <= '0;
      hgt_q <= '0;
      thr_q <= '0;
      hrb_q <= '0;
      vrb_q <= '0;
    end else begin
      run_q <= run_d;
      een_q <= een_d;
      wid_q <= wid_d;
      hgt_q <= hgt_d;
      thr_q <= thr_d;
      hrb_q <= hrb_d;
      vrb_q <= vrb_d;
    end
  end

  assign run_o       = run_q;
  assign edge_en_o   = een_q;
  assign width_o     = wid_q;
  assign height_o    = hgt_q;
  assign thresh_o    = thr_q;
  assign h_rd_bank_o = hrb_q;
  assign v_rd_bank_o = vrb_q;

endmodule

// File: rtl/scl_coef_mem.sv
module scl_coef_mem #(
  parameter int BANKS  = 2,
  parameter int PHASES = 8,
  parameter int NTAPS  = 4,
  parameter int COEF_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cm_vld,
  input  logic                      cm_dir,
  input  logic                      cm_edge,
  input  logic [$clog2(PHASES)-1:0] cm_phase,
  input  logic [$clog2(BANKS)-1:0]  cm_bank,
  input  logic [NTAPS*COEF_W-1:0]   taps,
  input  logic                      run,
  input  logic [$clog2(BANKS)-1:0]  h_rd_bank,
  input  logic [$clog2(BANKS)-1:0]  v_rd_bank,
  input  logic                      cr_en,
  input  logic                      cr_dir,
  input  logic                      cr_edge,
  input  logic [$clog2(PHASES)-1:0] cr_phase,
  input  logic [$clog2(NTAPS)-1:0]  cr_tap,
  output logic                      we_o,
  output logic [COEF_W-1:0]         cr_data
);

  localparam int BK_W = $clog2(BANKS);
  localparam int PH_W = $clog2(PHASES);
  localparam int RW_W = 2 + BK_W + PH_W;
  localparam int ROWS = 1 << RW_W;

  logic [BK_W-1:0]         act_bank, rd_bank;
  logic [RW_W-1:0]         wr_row, rd_row;
  logic [NTAPS*COEF_W-1:0] row_rd;
  logic [COEF_W-1:0]       cr_q, cr_d;

  // guard of the bank the datapath is reading
  assign act_bank = cm_dir ? v_rd_bank : h_rd_bank;
  assign we_o     = cm_vld && !(run && (cm_bank == act_bank));
  assign wr_row   = {cm_dir, cm_bank, cm_edge, cm_phase};

  assign rd_bank  = cr_dir ? v_rd_bank : h_rd_bank;
  assign rd_row   = {cr_dir, rd_bank, cr_edge, cr_phase};

  for (genvar t = 0; t < NTAPS; t++) begin : g_col
    logic [COEF_W-1:0] col [ROWS];
    always_ff @(posedge clk) begin
      if (we_o) col[wr_row] <= taps[t*COEF_W +: COEF_W];
    end
    assign row_rd[t*COEF_W +: COEF_W] = col[rd_row];
  end

  always_comb begin
    cr_d = cr_q;
    if (cr_en) begin
      cr_d = '0;
      for (int t = 0; t < NTAPS; t++) begin
        if (cr_tap == $clog2(NTAPS)'(t)) cr_d = row_rd[t*COEF_W +: COEF_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cr_q <= '0;
    else        cr_q <= cr_d;
  end

  assign cr_data = cr_q;

endmodule

// File: rtl/scl_coef_regs.sv
module scl_coef_regs #(
  parameter int ADDR_W   = 5,
  parameter int TAPS_H   = 4,
  parameter int TAPS_V   = 4,
  parameter int PHASES   = 8,
  parameter int BANKS    = 2,
  parameter int COEF_W   = 16,
  parameter int DIM_W    = 16,
  parameter int TH_W     = 16,
  parameter int PLANES   = 3,
  parameter int RUN_CTRL = 1,
  localparam int NTAPS   = (TAPS_H > TAPS_V) ? TAPS_H : TAPS_V,
  localparam int BK_W    = $clog2(BANKS),
  localparam int PH_W    = $clog2(PHASES),
  localparam int TP_W    = $clog2(NTAPS),
  localparam int THO_W   = TH_W + $clog2(PLANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  input  logic              frame_start,
  output logic              run_active,
  output logic              edge_adapt,
  output logic [DIM_W-1:0]  out_width,
  output logic [DIM_W-1:0]  out_height,
  output logic [THO_W-1:0]  edge_thresh,
  output logic [BK_W-1:0]   h_rd_bank,
  output logic [BK_W-1:0]   v_rd_bank,
  input  logic              cr_en,
  input  logic              cr_dir,
  input  logic              cr_edge,
  input  logic [PH_W-1:0]   cr_phase,
  input  logic [TP_W-1:0]   cr_tap,
  output logic [COEF_W-1:0] cr_data
);

  // asynchronous assertion, synchronous release
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic                    ctrl_go, ctrl_een;
  logic [DIM_W-1:0]        reg_wid, reg_hgt;
  logic [TH_W-1:0]         reg_thr;
  logic [BK_W-1:0]         reg_hrb, reg_vrb;
  logic [NTAPS*COEF_W-1:0] staged;
  logic                    cm_vld, cm_dir, cm_edge, mem_we;
  logic [PH_W-1:0]         cm_phase;
  logic [BK_W-1:0]         cm_bank;

  scl_coef_csr #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .TH_W(TH_W), .BK_W(BK_W), .PH_W(PH_W),
    .NTAPS(NTAPS), .COEF_W(COEF_W), .RUN_CTRL(RUN_CTRL)
  ) u_csr (
    .clk(clk), .rst_n(rst_sn), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .be(bus_be), .status_i(run_active), .rdata(bus_rdata),
    .go_o(ctrl_go), .edge_en_o(ctrl_een), .width_o(reg_wid), .height_o(reg_hgt),
    .thresh_o(reg_thr), .h_rd_bank_o(reg_hrb), .v_rd_bank_o(reg_vrb),
    .taps_o(staged), .cm_vld_o(cm_vld), .cm_dir_o(cm_dir), .cm_edge_o(cm_edge),
    .cm_phase_o(cm_phase), .cm_bank_o(cm_bank)
  );

  scl_coef_shadow #(
    .DIM_W(DIM_W), .TH_W(TH_W), .THO_W(THO_W), .BK_W(BK_W), .PLANES(PLANES)
  ) u_shadow (
    .clk(clk), .rst_n(rst_sn), .frame_start(frame_start), .go_i(ctrl_go),
    .edge_en_i(ctrl_een), .width_i(reg_wid), .height_i(reg_hgt), .thresh_i(reg_thr),
    .h_rd_bank_i(reg_hrb), .v_rd_bank_i(reg_vrb), .run_o(run_active),
    .edge_en_o(edge_adapt), .width_o(out_width), .height_o(out_height),
    .thresh_o(edge_thresh), .h_rd_bank_o(h_rd_bank), .v_rd_bank_o(v_rd_bank)
  );

  scl_coef_mem #(
    .BANKS(BANKS), .PHASES(PHASES), .NTAPS(NTAPS), .COEF_W(COEF_W)
  ) u_mem (
    .clk(clk), .rst_n(rst_sn), .cm_vld(cm_vld), .cm_dir(cm_dir), .cm_edge(cm_edge),
    .cm_phase(cm_phase), .cm_bank(cm_bank), .taps(staged), .run(run_active),
    .h_rd_bank(h_rd_bank), .v_rd_bank(v_rd_bank), .cr_en(cr_en), .cr_dir(cr_dir),
    .cr_edge(cr_edge), .cr_phase(cr_phase), .cr_tap(cr_tap), .we_o(mem_we),
    .cr_data(cr_data)
  );

endmodule

// File: rtl/scl_coef_regs_chk.sv
module scl_coef_regs_chk #(
  parameter int DIM_W    = 16,
  parameter int TH_W     = 16,
  parameter int THO_W    = 18,
  parameter int BK_W     = 1,
  parameter int PLANES   = 3,
  parameter int RUN_CTRL = 1
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             frame_start,
  input logic             run_active,
  input logic             ctrl_go,
  input logic [DIM_W-1:0] reg_wid,
  input logic [DIM_W-1:0] out_width,
  input logic [TH_W-1:0]  reg_thr,
  input logic [THO_W-1:0] edge_thresh,
  input logic             cm_vld,
  input logic             cm_dir,
  input logic [BK_W-1:0]  cm_bank,
  input logic [BK_W-1:0]  h_rd_bank,
  input logic [BK_W-1:0]  v_rd_bank,
  input logic             mem_we
);

  AST_RUN_FROM_GO: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_start |=> run_active == $past(ctrl_go));                          // R4
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !frame_start |=> $stable(run_active));                                  // R4
  AST_WIDTH_LATCH: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_start |=> out_width == $past(reg_wid));                           // R5
  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !frame_start |=> $stable(out_width));                                   // R5
  AST_THRESH_SCALE: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_start |=> edge_thresh == THO_W'($past(reg_thr)) * THO_W'(PLANES)); // R6
  AST_STOPPED_COMMIT: assert property (@(posedge clk) disable iff (!rst_sn)
    (cm_vld && !run_active) |-> mem_we);                                    // R8
  AST_ACTIVE_BANK_SAFE: assert property (@(posedge clk) disable iff (!rst_sn)
    (cm_vld && run_active && cm_bank == (cm_dir ? v_rd_bank : h_rd_bank)) |-> !mem_we); // R11
  AST_NO_SPURIOUS_WE: assert property (@(posedge clk) disable iff (!rst_sn)
    !cm_vld |-> !mem_we);                                                   // R8

  if (RUN_CTRL == 0) begin : g_tied
    AST_GO_TIED: assert property (@(posedge clk) disable iff (!rst_sn)
      ctrl_go);                                                             // R1
  end

endmodule

bind scl_coef_regs scl_coef_regs_chk #(
  .DIM_W(DIM_W), .TH_W(TH_W), .THO_W(THO_W), .BK_W(BK_W),
  .PLANES(PLANES), .RUN_CTRL(RUN_CTRL)
) u_chk (
  .clk(clk), .rst_sn(rst_sn), .frame_start(frame_start), .run_active(run_active),
  .ctrl_go(ctrl_go), .reg_wid(reg_wid), .out_width(out_width), .reg_thr(reg_thr),
  .edge_thresh(edge_thresh), .cm_vld(cm_vld), .cm_dir(cm_dir), .cm_bank(cm_bank),
  .h_rd_bank(h_rd_bank), .v_rd_bank(v_rd_bank), .mem_we(mem_we)
);

// File: tb/scl_coef_regs_test.sv
`timescale 1ns/1ps
module scl_coef_regs_test;

  localparam int ADDR_W = 5, TAPS_H = 4, TAPS_V = 3, PHASES = 4, BANKS = 4;
  localparam int COEF_W = 12, DIM_W = 12, TH_W = 10, PLANES = 3;
  localparam int THO_W  = TH_W + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [3:0]        bus_be = '0;
  logic [31:0]       bus_rdata;
  logic              frame_start = 1'b0;
  logic              run_active, edge_adapt;
  logic [DIM_W-1:0]  out_width, out_height;
  logic [THO_W-1:0]  edge_thresh;
  logic [1:0]        h_rd_bank, v_rd_bank;
  logic              cr_en = 1'b0, cr_dir = 1'b0, cr_edge = 1'b0;
  logic [1:0]        cr_phase = '0, cr_tap = '0;
  logic [COEF_W-1:0] cr_data;

  always #2.5 clk = ~clk;

  scl_coef_regs #(
    .ADDR_W(ADDR_W), .TAPS_H(TAPS_H), .TAPS_V(TAPS_V), .PHASES(PHASES),
    .BANKS(BANKS), .COEF_W(COEF_W), .DIM_W(DIM_W), .TH_W(TH_W),
    .PLANES(PLANES), .RUN_CTRL(1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .frame_start(frame_start), .run_active(run_active), .edge_adapt(edge_adapt),
    .out_width(out_width), .out_height(out_height), .edge_thresh(edge_thresh),
    .h_rd_bank(h_rd_bank), .v_rd_bank(v_rd_bank), .cr_en(cr_en), .cr_dir(cr_dir),
    .cr_edge(cr_edge), .cr_phase(cr_phase), .cr_tap(cr_tap), .cr_data(cr_data)
  );

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0, cr_seen = 1'b0;
  bit          done = 1'b0;

  function automatic logic [COEF_W-1:0] cval(input int set, input int tap);
    return COEF_W'(set * 16 + tap + 1);
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard when a read result is due
  always @(posedge clk) begin
    rd_seen <= bus_rd;
    cr_seen <= cr_en;
  end

  always @(negedge clk) begin
    if (rd_seen || cr_seen) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R12: read result with no expected item, got %0h expected none", bus_rdata);
      end else begin
        check(rd_seen ? bus_rdata : 32'(cr_data), exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  // drivers (entered at a falling edge)
  task automatic bus_write(input int a, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic coef_read(input logic d, input logic e, input int ph, input int tp,
                           input logic [31:0] exp, input string tag);
    cr_en = 1'b1; cr_dir = d; cr_edge = e; cr_phase = 2'(ph); cr_tap = 2'(tp);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    cr_en = 1'b0;
  endtask

  task automatic load_taps(input int set);
    for (int i = 0; i < 4; i++) bus_write(14 + i, 32'(cval(set, i)), 4'hF);
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(32'(run_active), 0, "R1 status after reset");
    check(32'(out_width), 0, "R1 width shadow after reset");
    check(32'(edge_adapt), 0, "R1 edge enable after reset");
    check(bus_rdata, 0, "R1 rdata after reset");
    bus_read(0, 0, "R1 control after reset");
    bus_read(12, 0, "R1 phase after reset");
    bus_read(14, 0, "R1 tap after reset");

    // R3 control bits, unused locations
    bus_write(0, 32'hFFFF_FFFF, 4'hF);
    bus_read(0, 3, "R3 control used bits");
    bus_write(0, 0, 4'hF);
    bus_write(2, 32'hFFFF_FFFF, 4'hF);
    bus_read(2, 0, "R3 interrupt reads zero");
    bus_write(6, 32'hFFFF_FFFF, 4'hF);
    bus_read(6, 0, "R3 reserved reads zero");

    // R2 byte lanes, R12 hold of read data
    bus_write(3, 32'h0000_0ABC, 4'b0001);
    bus_read(3, 32'h0BC, "R2 low lane only");
    bus_write(3, 32'hFFFF_05FF, 4'b0010);
    bus_read(3, 32'h5BC, "R2 second lane only");
    @(negedge clk);
    check(bus_rdata, 32'h5BC, "R12 read data held");
    bus_write(4, 32'h2D0, 4'hF);
    bus_write(5, 100, 4'hF);
    check(32'(out_width), 0, "R5 width not yet latched");

    pulse_frame();
    check(32'(out_width), 32'h5BC, "R5 width latched");
    check(32'(out_height), 32'h2D0, "R5 height latched");
    check(32'(edge_thresh), 300, "R6 threshold times planes");
    check(32'(run_active), 0, "R4 not started");

    // R7 staging, R8 commit into write bank, R10 read port
    load_taps(1);
    bus_read(15, 32'(cval(1, 1)), "R7 staged tap read back");
    bus_write(8, 2, 4'hF);
    bus_write(9, 2, 4'hF);
    check(32'(h_rd_bank), 0, "R5 read bank not yet latched");
    bus_write(12, 1, 4'hF);
    pulse_frame();
    check(32'(h_rd_bank), 2, "R5 read bank latched");
    for (int t = 0; t < 4; t++) coef_read(1'b0, 1'b0, 1, t, 32'(cval(1, t)), "R10 horizontal phase 1");

    // R9 edge set
    load_taps(2);
    coef_read(1'b0, 1'b0, 1, 0, 32'(cval(1, 0)), "R7 staging leaves store");
    bus_write(12, 32'h8001, 4'hF);
    bus_read(12, 32'h8001, "R9 phase readback with edge bit");
    coef_read(1'b0, 1'b1, 1, 2, 32'(cval(2, 2)), "R9 edge set written");
    coef_read(1'b0, 1'b0, 1, 2, 32'(cval(1, 2)), "R9 normal set untouched");

    // R8 same phase recommit
    load_taps(3);
    bus_write(12, 1, 4'hF);
    coef_read(1'b0, 1'b0, 1, 3, 32'(cval(3, 3)), "R8 repeated phase commits");

    // R8 vertical
    bus_write(10, 1, 4'hF);
    bus_write(11, 1, 4'hF);
    load_taps(4);
    bus_write(13, 3, 4'hF);
    pulse_frame();
    check(32'(v_rd_bank), 1, "R5 vertical read bank");
    coef_read(1'b1, 1'b0, 3, 2, 32'(cval(4, 2)), "R8 vertical commit");

    // R4 start
    bus_write(0, 3, 4'hF);
    check(32'(run_active), 0, "R4 go waits for frame start");
    bus_read(1, 0, "R4 status before start");
    pulse_frame();
    check(32'(run_active), 1, "R4 running after frame start");
    check(32'(edge_adapt), 1, "R5 edge enable latched");
    bus_read(1, 1, "R4 status running");

    // R11 blocked commit to the active bank
    load_taps(5);
    bus_write(12, 1, 4'hF);
    coef_read(1'b0, 1'b0, 1, 1, 32'(cval(3, 1)), "R11 active bank intact");
    bus_write(8, 3, 4'hF);
    bus_write(12, 1, 4'hF);
    bus_write(9, 3, 4'hF);
    check(32'(h_rd_bank), 2, "R5 read bank held mid-frame");
    coef_read(1'b0, 1'b0, 1, 1, 32'(cval(3, 1)), "R5 still reading old bank");
    pulse_frame();
    coef_read(1'b0, 1'b0, 1, 1, 32'(cval(5, 1)), "R11 inactive bank commit kept");

    // R4 stop, R11 commit allowed once stopped
    bus_write(0, 0, 4'hF);
    check(32'(run_active), 1, "R4 stop waits for frame start");
    pulse_frame();
    check(32'(run_active), 0, "R4 stopped");
    load_taps(6);
    bus_write(12, 0, 4'hF);
    coef_read(1'b0, 1'b0, 0, 3, 32'(cval(6, 3)), "R11 stopped commit to read bank");

    repeat (3) @(negedge clk);
    check(32'(exp_q.size()), 0, "R12 all reads answered");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule